// File: doc/BRIEF.md
# Receive Buffer Ring Fetcher

This block keeps track of where incoming frames are stored. Memory holds a circular table of buffer descriptors; each descriptor is four 16-bit words that give a buffer's base address and its size in 16-bit words. A fetch can be requested by command or can be triggered automatically. A fetch reads the descriptor at the current read pointer and loads the buffer address and remaining word count. It then moves the read pointer forward, wrapping it at the end of the table. When the read pointer catches up with the write pointer that software maintains, the block reports that the table has run dry.

After every accepted frame, the receive path pulses `pkt_done` with the frame length in bytes. The block then moves the buffer address past the frame and its four-byte check sequence, and lowers the remaining count to match. When the remaining space falls below a programmable low-water mark, the block flags the frame as the last one in its buffer and fetches the next descriptor without being told to. The packet data transfer itself belongs to another block.

Top module: `rx_ring_fetcher`

## Requirements
- R1: A fetch reads four 16-bit words, one at a time. The address of word k is {upper_addr, rd_ptr} + k*slot, where slot is 2 bytes when cfg_wide=0 and 4 bytes when cfg_wide=1. Word 0 is the buffer address low half, word 1 the address high half, word 2 the count low half and word 3 the count high half. buf_addr and word_count take the fetched values in the cycle after word 3 is accepted.
- R2: Each completed fetch advances rd_ptr by 8 when cfg_wide=0, or by 16 when cfg_wide=1, modulo 2^16.
- R3: If the advanced pointer equals ring_end with bit 0 cleared, rd_ptr is set to ring_start with bit 0 cleared.
- R4: If the final pointer equals wr_ptr with bit 0 cleared, exhausted is set. It stays set until a clear_exhaust pulse. rx_ready is the inverse of exhausted.
- R5: busy rises in the cycle after a fetch starts and falls in the cycle after word 3 is accepted. mem_req is high only while busy, and the memory address holds until mem_rvalid.
- R6: A pkt_done pulse while rx_ready is high subtracts (pkt_bytes+4)/2 from word_count and adds pkt_bytes+4 to buf_addr.
- R7: A pkt_done pulse while exhausted is high leaves buf_addr and word_count unchanged.
- R8: If the count after an accepted frame is below eob_count (unsigned, 32-bit), last_in_buf is high for the next cycle and a fetch is started. If a fetch is already running, the new one is held pending.
- R9: eob_count is 0x02F8 after reset. An eob_we pulse loads eob_wdata into it.
- R10: Fetch requests that arrive while busy are combined into one pending fetch. That fetch starts one idle cycle after the current fetch completes and uses the updated pointer.
- R11: An rrp_we pulse while idle loads rd_ptr with rrp_wdata with bit 0 cleared. An rrp_we pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wide | input | 1 | 1: descriptor words in 32-bit slots |
| upper_addr | input | 16 | Shared upper address half of the table |
| ring_start | input | 16 | Table start pointer (bit 0 ignored) |
| ring_end | input | 16 | Table end pointer (bit 0 ignored) |
| wr_ptr | input | 16 | Software write pointer (bit 0 ignored) |
| rrp_we | input | 1 | Load the read pointer |
| rrp_wdata | input | 16 | Value for the read pointer |
| fetch_req | input | 1 | Command: fetch one descriptor |
| clear_exhaust | input | 1 | Clear the exhausted flag |
| eob_we | input | 1 | Load the low-water mark |
| eob_wdata | input | 16 | Value for the low-water mark |
| pkt_done | input | 1 | A frame was stored |
| pkt_bytes | input | 16 | Length of that frame in bytes |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read byte address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data |
| busy | output | 1 | Fetch in progress (the read-resource command bit) |
| rd_ptr | output | 16 | Current read pointer |
| exhausted | output | 1 | Table run dry |
| rx_ready | output | 1 | Frames are accepted |
| buf_addr | output | 32 | Current buffer byte address |
| word_count | output | 32 | Remaining 16-bit words in buffer |
| eob_count | output | 16 | Low-water mark |
| last_in_buf | output | 1 | Last frame in buffer (one cycle) |

## Verification
The assertions run on every cycle and check the following:
- the memory request stays steady between responses;
- a held request starts in the idle cycle after it;
- the exhausted flag stays set until it is cleared;
- the read pointer moves only on a commit or an idle load;
- a wrap reloads the start pointer;
- a refused frame leaves the buffer state alone;
- a low-water hit starts a fetch.

Only the bench scenarios can show the following:
- the word order in the descriptor and the slot spacing in each width;
- that exactly one extra fetch results from a burst of requests;
- that a pointer load during a fetch is lost;
- that the reset value of the low-water mark is correct.

Each of these is checked against a reference model that is stepped every clock.

// File: rtl/rrf_pkg.sv
package rrf_pkg;
  localparam int PTR_W      = 16;
  localparam int ADDR_W     = 2 * PTR_W;
  localparam int DESC_WORDS = 4;
  localparam int IDX_W      = $clog2(DESC_WORDS);
  localparam logic [PTR_W-1:0] EOB_RESET = 16'h02F8;
  localparam logic [PTR_W-1:0] EVEN_MASK = {{(PTR_W-1){1'b1}}, 1'b0};

  // bytes consumed in the table per descriptor
  function automatic logic [PTR_W-1:0] desc_stride(input logic wide);
    return wide ? PTR_W'(DESC_WORDS * 4) : PTR_W'(DESC_WORDS * 2);
  endfunction

  // pointer after one fetch, including the wrap to the start
  function automatic logic [PTR_W-1:0] ring_next(input logic [PTR_W-1:0] ptr,
                                                 input logic wide,
                                                 input logic [PTR_W-1:0] first,
                                                 input logic [PTR_W-1:0] last);
    logic [PTR_W-1:0] n;
    n = ptr + desc_stride(wide);
    if (n == (last & EVEN_MASK)) n = first & EVEN_MASK;
    return n;
  endfunction

  // bytes a frame occupies, check sequence included
  function automatic logic [ADDR_W-1:0] frame_bytes(input logic [PTR_W-1:0] len);
    return ADDR_W'(len) + ADDR_W'(4);
  endfunction

  function automatic logic [ADDR_W-1:0] frame_words(input logic [PTR_W-1:0] len);
    return frame_bytes(len) >> 1;
  endfunction
endpackage

// File: rtl/rrf_fetch_seq.sv
module rrf_fetch_seq
  import rrf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic              cfg_wide,
  input  logic [ADDR_W-1:0] base_addr,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [PTR_W-1:0]  mem_rdata,
  output logic              busy,
  output logic              commit,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [ADDR_W-1:0] commit_count
);
  logic             busy_q, pend_q;
  logic [IDX_W-1:0] idx_q;
  logic [PTR_W-1:0] shadow_q [DESC_WORDS-1];
  logic             take, last_word;

  assign take      = busy_q & mem_rvalid;
  assign last_word = (idx_q == IDX_W'(DESC_WORDS - 1));
  assign commit    = take & last_word;
  assign mem_req   = busy_q;
  assign busy      = busy_q;
  assign mem_addr  = base_addr + (ADDR_W'(idx_q) << (cfg_wide ? 2 : 1));
  assign commit_addr  = {shadow_q[1], shadow_q[0]};
  assign commit_count = {mem_rdata, shadow_q[2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pend_q <= 1'b0;
      idx_q  <= '0;
    end else if (!busy_q) begin
      if (start_req || pend_q) begin
        busy_q <= 1'b1;
        pend_q <= 1'b0;
        idx_q  <= '0;
      end
    end else begin
      if (start_req) pend_q <= 1'b1;
      if (take) begin
        if (last_word) busy_q <= 1'b0;
        else           idx_q  <= idx_q + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < DESC_WORDS - 1; g++) begin : g_shadow
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            shadow_q[g] <= '0;
      else if (take && idx_q == IDX_W'(g))   shadow_q[g] <= mem_rdata;
    end
  end

  a_r5_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !mem_rvalid) |=> (busy_q && $stable(idx_q)));
  a_r10_pending_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && pend_q) |=> (busy_q && idx_q == '0));
endmodule

// File: rtl/rrf_ptr_unit.sv
module rrf_ptr_unit
  import rrf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wide,
  input  logic [PTR_W-1:0] ring_start,
  input  logic [PTR_W-1:0] ring_end,
  input  logic [PTR_W-1:0] wr_ptr,
  input  logic             load_en,
  input  logic [PTR_W-1:0] load_val,
  input  logic             commit,
  input  logic             clear_exh,
  output logic [PTR_W-1:0] rd_ptr,
  output logic             exhausted,
  output logic             wrap_evt
);
  logic [PTR_W-1:0] ptr_q, nxt;
  logic             exh_q, meets_wr;

  assign nxt      = ring_next(ptr_q, cfg_wide, ring_start, ring_end);
  assign meets_wr = (nxt == (wr_ptr & EVEN_MASK));
  assign wrap_evt = commit && ((ptr_q + desc_stride(cfg_wide)) == (ring_end & EVEN_MASK));
  assign rd_ptr    = ptr_q;
  assign exhausted = exh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      exh_q <= 1'b0;
    end else begin
      if (load_en)     ptr_q <= load_val & EVEN_MASK;
      else if (commit) ptr_q <= nxt;
      if (commit && meets_wr) exh_q <= 1'b1;
      else if (clear_exh)     exh_q <= 1'b0;
    end
  end

  a_r4_exhaust_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (exh_q && !clear_exh) |=> exh_q);
  a_r2_ptr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && !load_en) |=> $stable(ptr_q));
  a_r3_wrap_to_start: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (ptr_q == ($past(ring_start) & EVEN_MASK)));
endmodule

// File: rtl/rrf_buf_track.sv
module rrf_buf_track
  import rrf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_done,
  input  logic [PTR_W-1:0]  pkt_bytes,
  input  logic              exhausted,
  input  logic              commit,
  input  logic [ADDR_W-1:0] commit_addr,
  input  logic [ADDR_W-1:0] commit_count,
  input  logic              eob_we,
  input  logic [PTR_W-1:0]  eob_wdata,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [ADDR_W-1:0] word_count,
  output logic [PTR_W-1:0]  eob_count,
  output logic              last_in_buf,
  output logic              auto_req
);
  logic [ADDR_W-1:0] addr_q, wc_q, wc_after;
  logic [PTR_W-1:0]  eob_q;
  logic              last_q, accept;

  assign accept   = pkt_done & ~exhausted;
  assign wc_after = wc_q - frame_words(pkt_bytes);
  assign auto_req = accept && (wc_after < ADDR_W'(eob_q));
  assign buf_addr    = addr_q;
  assign word_count  = wc_q;
  assign eob_count   = eob_q;
  assign last_in_buf = last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wc_q   <= '0;
      eob_q  <= EOB_RESET;
      last_q <= 1'b0;
    end else begin
      last_q <= auto_req;
      if (eob_we) eob_q <= eob_wdata;
      if (commit) begin
        addr_q <= commit_addr;
        wc_q   <= commit_count;
      end else if (accept) begin
        addr_q <= addr_q + frame_bytes(pkt_bytes);
        wc_q   <= wc_after;
      end
    end
  end

  a_r7_refused_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && exhausted && !commit) |=> ($stable(wc_q) && $stable(addr_q)));
  a_r9_eob_load: assert property (@(posedge clk) disable iff (!rst_n)
    eob_we |=> (eob_q == $past(eob_wdata)));
endmodule

// File: rtl/rx_ring_fetcher.sv
module rx_ring_fetcher
  import rrf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wide,
  input  logic [15:0] upper_addr,
  input  logic [15:0] ring_start,
  input  logic [15:0] ring_end,
  input  logic [15:0] wr_ptr,
  input  logic        rrp_we,
  input  logic [15:0] rrp_wdata,
  input  logic        fetch_req,
  input  logic        clear_exhaust,
  input  logic        eob_we,
  input  logic [15:0] eob_wdata,
  input  logic        pkt_done,
  input  logic [15:0] pkt_bytes,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [15:0] mem_rdata,
  output logic        busy,
  output logic [15:0] rd_ptr,
  output logic        exhausted,
  output logic        rx_ready,
  output logic [31:0] buf_addr,
  output logic [31:0] word_count,
  output logic [15:0] eob_count,
  output logic        last_in_buf
);
  logic              commit, auto_req, wrap_evt, load_en;
  logic [ADDR_W-1:0] commit_addr, commit_count;

  assign load_en  = rrp_we & ~busy;
  assign rx_ready = ~exhausted;

  rrf_fetch_seq u_seq (
    .clk, .rst_n,
    .start_req   (fetch_req | auto_req),
    .cfg_wide,
    .base_addr   ({upper_addr, rd_ptr}),
    .mem_req, .mem_addr, .mem_rvalid, .mem_rdata,
    .busy, .commit, .commit_addr, .commit_count
  );

  rrf_ptr_unit u_ptr (
    .clk, .rst_n, .cfg_wide, .ring_start, .ring_end, .wr_ptr,
    .load_en, .load_val (rrp_wdata), .commit,
    .clear_exh (clear_exhaust),
    .rd_ptr, .exhausted, .wrap_evt
  );

  rrf_buf_track u_buf (
    .clk, .rst_n, .pkt_done, .pkt_bytes, .exhausted, .commit,
    .commit_addr, .commit_count, .eob_we, .eob_wdata,
    .buf_addr, .word_count, .eob_count, .last_in_buf, .auto_req
  );

  a_r8_low_water_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_req && !busy) |=> busy);
  a_r11_load_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (rrp_we && busy && !commit) |=> $stable(rd_ptr));
endmodule

// File: tb/rx_ring_fetcher_tb_top.sv
module rx_ring_fetcher_tb_top;
  logic clk = 0, rst_n = 0;
  logic cfg_wide = 0, rrp_we = 0, fetch_req = 0, clear_exhaust = 0, eob_we = 0, pkt_done = 0;
  logic [15:0] upper_addr = 0, ring_start = 0, ring_end = 0, wr_ptr = 0;
  logic [15:0] rrp_wdata = 0, eob_wdata = 0, pkt_bytes = 0;
  logic mem_rvalid = 0; logic [15:0] mem_rdata = 0;
  logic mem_req, busy, exhausted, rx_ready, last_in_buf;
  logic [31:0] mem_addr, buf_addr, word_count;
  logic [15:0] rd_ptr, eob_count;

  rx_ring_fetcher dut_i (.*);

  always #10 clk = ~clk;

  int n_checks = 0, n_fail = 0;
  logic [15:0] mem [int unsigned];
  int lat = 0;
  logic [31:0] seen[$];
  bit started = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] rd_mem(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return a[15:0] ^ 16'h5A5A;
  endfunction

  // memory responder
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (mem_rvalid) mem_rvalid = 0;
      else if (mem_req) begin
        if (cnt >= lat) begin
          mem_rvalid = 1; mem_rdata = rd_mem(mem_addr); seen.push_back(mem_addr); cnt = 0;
        end else cnt++;
      end else cnt = 0;
    end
  end

  // behavioural reference model
  logic [15:0] m_ptr = 0, m_eob = 16'h02F8;
  logic [31:0] m_addr = 0, m_wc = 0;
  bit m_exh = 0, m_busy = 0, m_pend = 0, m_last = 0;
  logic [15:0] m_q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ptr = 0; m_eob = 16'h02F8; m_addr = 0; m_wc = 0;
      m_exh = 0; m_busy = 0; m_pend = 0; m_last = 0; m_q.delete();
    end else begin
      bit acc, low, req, cmt;
      logic [31:0] nwc;
      int n;
      acc = pkt_done && !m_exh;
      nwc = m_wc - ((32'(pkt_bytes) + 4) / 2);
      low = acc && (nwc < 32'(m_eob));
      req = fetch_req || low;
      cmt = m_busy && mem_rvalid && (m_q.size() == 3);
      m_last = low;
      if (acc) begin m_wc = nwc; m_addr = m_addr + 32'(pkt_bytes) + 4; end
      if (clear_exhaust) m_exh = 0;
      if (cmt) begin
        m_addr = {m_q[1], m_q[0]};
        m_wc = {mem_rdata, m_q[2]};
        n = (int'(m_ptr) + (cfg_wide ? 16 : 8)) % 65536;
        if (n == int'(ring_end & 16'hFFFE)) n = int'(ring_start & 16'hFFFE);
        m_ptr = 16'(n);
        if (n == int'(wr_ptr & 16'hFFFE)) m_exh = 1;
      end
      if (rrp_we && !m_busy) m_ptr = rrp_wdata & 16'hFFFE;
      if (eob_we) m_eob = eob_wdata;
      if (!m_busy) begin
        if (req || m_pend) begin m_busy = 1; m_pend = 0; m_q.delete(); end
      end else begin
        if (req) m_pend = 1;
        if (mem_rvalid) begin
          if (cmt) begin m_busy = 0; m_q.delete(); end
          else m_q.push_back(mem_rdata);
        end
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) if (started) begin
    check(rd_ptr == m_ptr, "R2", "rd_ptr", rd_ptr, m_ptr);
    check(exhausted == m_exh && rx_ready == !m_exh, "R4", "exhausted", exhausted, m_exh);
    check(buf_addr == m_addr, "R6", "buf_addr", buf_addr, m_addr);
    check(word_count == m_wc, "R6", "word_count", word_count, m_wc);
    check(busy == m_busy && mem_req == m_busy, "R5", "busy", busy, m_busy);
    check(last_in_buf == m_last, "R8", "last_in_buf", last_in_buf, m_last);
    check(eob_count == m_eob, "R9", "eob_count", eob_count, m_eob);
    if (m_busy)
      check(mem_addr == ({upper_addr, m_ptr} + 32'(m_q.size() * (cfg_wide ? 4 : 2))),
            "R1", "mem_addr", mem_addr, {upper_addr, m_ptr} + 32'(m_q.size() * (cfg_wide ? 4 : 2)));
  end

  task automatic wait_idle();
    for (int i = 0; i < 400 && busy; i++) @(negedge clk);
  endtask
  task automatic fetch();
    fetch_req = 1; @(negedge clk); fetch_req = 0; wait_idle();
  endtask
  task automatic pkt(input logic [15:0] b);
    pkt_done = 1; pkt_bytes = b; @(negedge clk); pkt_done = 0;
  endtask

  initial begin
    upper_addr = 16'h0010; ring_start = 16'h0101; ring_end = 16'h0121; wr_ptr = 16'h0118;
    mem[32'h0010_0100] = 16'h2000; mem[32'h0010_0102] = 16'h0004;
    mem[32'h0010_0104] = 16'h0400; mem[32'h0010_0106] = 16'h0000;
    mem[32'h0010_0108] = 16'h3000; mem[32'h0010_010A] = 16'h0005;
    mem[32'h0010_010C] = 16'h0100; mem[32'h0010_010E] = 16'h0001;
    mem[32'h0010_0110] = 16'h4000; mem[32'h0010_0112] = 16'h0006;
    mem[32'h0010_0114] = 16'h0200; mem[32'h0010_0116] = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1; started = 1;
    check(eob_count == 16'h02F8, "R9", "eob reset", eob_count, 16'h02F8);
    check(!busy && !exhausted && rx_ready, "R5", "idle after reset", busy, 0);

    rrp_we = 1; rrp_wdata = 16'h0101; @(negedge clk); rrp_we = 0;
    check(rd_ptr == 16'h0100, "R11", "pointer load", rd_ptr, 16'h0100);

    seen.delete(); fetch();
    check(seen.size() == 4 && seen[0] == 32'h0010_0100 && seen[3] == 32'h0010_0106,
          "R1", "narrow word addresses", seen.size() > 0 ? seen[0] : 0, 32'h0010_0100);
    check(buf_addr == 32'h0004_2000, "R1", "buf_addr", buf_addr, 32'h0004_2000);
    check(word_count == 32'h400, "R1", "word_count", word_count, 32'h400);
    check(rd_ptr == 16'h0108, "R2", "narrow step", rd_ptr, 16'h0108);

    pkt(16'd60);
    check(word_count == 32'h3E0, "R6", "count after 60 bytes", word_count, 32'h3E0);
    check(buf_addr == 32'h0004_2040, "R6", "addr after 60 bytes", buf_addr, 32'h0004_2040);
    check(!last_in_buf && !busy, "R8", "above low-water", last_in_buf, 0);

    lat = 2;
    pkt(16'd500);
    check(word_count == 32'h2E4, "R6", "count after 500 bytes", word_count, 32'h2E4);
    check(last_in_buf && busy, "R8", "low-water auto fetch", {last_in_buf, busy}, 2'b11);
    wait_idle();
    check(buf_addr == 32'h0005_3000 && word_count == 32'h0001_0100, "R1", "auto fetch load",
          word_count, 32'h0001_0100);
    check(rd_ptr == 16'h0110 && !exhausted, "R2", "second step", rd_ptr, 16'h0110);

    lat = 0;
    fetch();
    check(rd_ptr == 16'h0118 && exhausted && !rx_ready, "R4", "meets write pointer", exhausted, 1);
    pkt(16'd100);
    check(word_count == 32'h200 && buf_addr == 32'h0006_4000, "R7", "refused frame", word_count, 32'h200);
    clear_exhaust = 1; @(negedge clk); clear_exhaust = 0;
    check(!exhausted && rx_ready, "R4", "cleared", exhausted, 0);

    fetch();
    check(rd_ptr == 16'h0100 && !exhausted, "R3", "wrap to start", rd_ptr, 16'h0100);

    fetch_req = 1; repeat (3) @(negedge clk); fetch_req = 0;
    wait_idle(); @(negedge clk); wait_idle();
    check(rd_ptr == 16'h0110 && !exhausted, "R10", "burst gives one extra fetch", rd_ptr, 16'h0110);

    cfg_wide = 1;
    rrp_we = 1; rrp_wdata = 16'h0100; @(negedge clk); rrp_we = 0;
    mem[32'h0010_0100] = 16'h1111; mem[32'h0010_0104] = 16'h0002;
    mem[32'h0010_0108] = 16'h0050; mem[32'h0010_010C] = 16'h0000;
    seen.delete(); lat = 1; fetch();
    check(seen.size() == 4 && seen[1] == 32'h0010_0104 && seen[3] == 32'h0010_010C,
          "R1", "wide word addresses", seen.size() > 1 ? seen[1] : 0, 32'h0010_0104);
    check(buf_addr == 32'h0002_1111 && word_count == 32'h50, "R1", "wide load", buf_addr, 32'h0002_1111);
    check(rd_ptr == 16'h0110, "R2", "wide step", rd_ptr, 16'h0110);

    eob_we = 1; eob_wdata = 16'h0100; @(negedge clk); eob_we = 0;
    check(eob_count == 16'h0100, "R9", "eob load", eob_count, 16'h0100);
    pkt(16'd10);
    check(word_count == 32'h49 && last_in_buf && busy, "R8", "wide low-water", word_count, 32'h49);
    rrp_we = 1; rrp_wdata = 16'h0150; @(negedge clk); rrp_we = 0;
    wait_idle();
    check(rd_ptr == 16'h0100, "R11", "load during fetch ignored, wrap R3", rd_ptr, 16'h0100);

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule